// File: doc/BRIEF.md
# Scatter-Gather Descriptor Table Walker

This block moves a device-side stream of 16-bit halfwords to or from host memory under the direction of a descriptor table. The table sits in host memory. It is a list of 8-byte entries, and each entry names one host buffer region and its length. After a start pulse, the walker reads entries one at a time from the table base. It streams halfwords between the device port and the region each entry describes, and it stops when the device transfer is complete or the table runs out.

A transfer is set up by presenting a table base address, a device byte total and a direction, then pulsing `start`. The walker fetches a new entry only when the current one is used up. Within an entry, the amount moved is the smaller of what the device still has to move and what the entry still has room for. A one-page bound on how far the walker reads into the table protects against a table that never sets its final-entry flag. At the end, `done` pulses for one cycle. `underrun` reports whether the table ended before the device byte total was reached.

All memory traffic is halfword-wide on a single request port that has a combinational acknowledge. Entries are read as four halfword reads.

Top module: `prd_walker`

## Requirements
- R1: After reset the walker is idle: `busy`, `done`, `underrun`, `memReq`, `devInReady` and `devOutValid` are all low.
- R2: An entry at table pointer P is read as halfword reads at P, P+2, P+4 and P+6, in that order. The buffer address is the halfword at P (low) joined with the halfword at P+2 (high). The control word is the halfword at P+4 (low) joined with the halfword at P+6 (high). Bits 1:0 of the table base are ignored.
- R3: The entry byte count is control bits 15:0 with bit 0 forced to zero. A count field of zero means 65536 bytes. The device byte total also has bit 0 forced to zero.
- R4: Control bit 31 set marks the final entry of the table.
- R5: A new entry is fetched only when the current entry has no bytes left and device bytes remain. No entry is read when the device total is zero.
- R6: Data beats for an entry start at its buffer address and step by 2, carrying across 16-bit boundaries. The bytes moved for an entry are the smaller of the device residue and the entry residue.
- R7: When the device residue reaches zero the walk ends: `done` pulses and `underrun` stays low, even if the current entry still has bytes.
- R8: If the table ends while device bytes remain, the walk ends with `underrun` high until the next accepted start. The table ends when the final entry is used up, or when the table pointer is PAGE_BYTES or more past the base when a fetch is due.
- R9: With `toHost`=1, each beat takes one device halfword (`devInValid`/`devInReady`) and writes it to host memory. With `toHost`=0, each beat reads host memory and presents the halfword on `devOutData` with `devOutValid` held until `devOutReady`.
- R10: `start` is accepted only while idle. Each accepted start reloads the table pointer from the base and the device residue from `devBytes`. A start while busy has no effect on the walk in progress.
- R11: `busy` is high from the cycle after an accepted start until `done`, and `done` is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (accepted when idle) |
| toHost | input | 1 | 1: device to host memory, 0: host memory to device |
| tableBase | input | 32 | Descriptor table base address |
| devBytes | input | CNT_W | Device byte total for the walk |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| underrun | output | 1 | Table ended before the device total was moved |
| memReq | output | 1 | Memory request |
| memWrite | output | 1 | Request is a write |
| memAddr | output | 32 | Request byte address |
| memWdata | output | 16 | Write halfword |
| memRdata | input | 16 | Read halfword, valid with memAck |
| memAck | input | 1 | Request accepted and completed this cycle |
| devInValid | input | 1 | Device halfword available (to-host direction) |
| devInData | input | 16 | Device halfword |
| devInReady | output | 1 | Device halfword consumed |
| devOutValid | output | 1 | Halfword for the device available |
| devOutData | output | 16 | Halfword for the device |
| devOutReady | input | 1 | Device takes the halfword |

## Verification
The bench sweeps the device total across a three-entry table whose last region crosses a 16-bit address boundary, in both directions, with and without back-pressure. A walker that took the larger residue, or that fetched the next entry early, would put beats at the wrong addresses or read surplus entries. An odd count, a zero count and a misaligned base check the decode. A walker that kept bit 0, treated zero as empty or used the raw base would move the wrong byte totals or read the wrong halfwords. A chain of non-final entries longer than the page bound, and a start pulsed mid-walk, catch a missing safety stop and a restart that corrupts a live walk.

// File: rtl/prd_walk_pkg.sv
package prd_walk_pkg;
  localparam int ADDR_W = 32;
  localparam int HW_W = 16;
  localparam int DESC_HALVES = 4;
  localparam int DESC_BYTES = DESC_HALVES * 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_FETCH,
    ST_MOVE,
    ST_PUSH,
    ST_DONE
  } walkState_t;

  typedef struct packed {
    logic loadStart;
    logic fetchAck;
    logic beatDone;
    logic holdRead;
    logic selTable;
  } walkStrobe_t;
endpackage

// File: rtl/prd_walk_dp.sv
module prd_walk_dp
  import prd_walk_pkg::*;
#(
  parameter int CNT_W = 20,
  parameter int PAGE_BYTES = 4096
) (
  input  logic              clk,
  input  logic              rstN,
  input  walkStrobe_t       strb,
  input  logic [ADDR_W-1:0] tableBase,
  input  logic [CNT_W-1:0]  devBytes,
  input  logic [HW_W-1:0]   memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [HW_W-1:0]   heldData,
  output logic              devRemZero,
  output logic              prdRemZero,
  output logic              lastDesc,
  output logic              pageHit,
  output logic              fetchLast
);
  localparam int PRD_W = HW_W + 1;
  localparam int IDX_W = $clog2(DESC_HALVES);
  localparam logic [PRD_W-1:0] FULL_PRD = PRD_W'(1) << HW_W;
  localparam logic [ADDR_W-1:0] PAGE_LIM = ADDR_W'(PAGE_BYTES);
  localparam logic [ADDR_W-1:0] PTR_BOUND = ADDR_W'(PAGE_BYTES + DESC_BYTES);

  logic [ADDR_W-1:0] baseReg;
  logic [ADDR_W-1:0] tblPtr;
  logic [ADDR_W-1:0] bufAddr;
  logic [PRD_W-1:0]  prdRem;
  logic [CNT_W-1:0]  devRem;
  logic [IDX_W-1:0]  fetchIdx;
  logic [HW_W-1:0]   descHalf [DESC_HALVES-1];
  logic [HW_W-1:0]   cntField;
  logic [ADDR_W-1:0] tblOffset;

  assign fetchLast  = fetchIdx == IDX_W'(DESC_HALVES - 1);
  assign cntField   = {descHalf[2][HW_W-1:1], 1'b0};
  assign tblOffset  = tblPtr - baseReg;
  assign pageHit    = tblOffset >= PAGE_LIM;
  assign devRemZero = devRem == '0;
  assign prdRemZero = prdRem == '0;
  assign memAddr    = strb.selTable ? tblPtr : bufAddr;

  // capture of the leading descriptor halfwords, one register per slot
  for (genvar i = 0; i < DESC_HALVES - 1; i++) begin : g_half
    always_ff @(posedge clk) begin
      if (!rstN) descHalf[i] <= '0;
      else if (strb.fetchAck && fetchIdx == IDX_W'(i)) descHalf[i] <= memRdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseReg  <= '0;
      tblPtr   <= '0;
      fetchIdx <= '0;
    end else if (strb.loadStart) begin
      baseReg  <= {tableBase[ADDR_W-1:2], 2'b00};
      tblPtr   <= {tableBase[ADDR_W-1:2], 2'b00};
      fetchIdx <= '0;
    end else if (strb.fetchAck) begin
      tblPtr   <= tblPtr + ADDR_W'(2);
      fetchIdx <= fetchIdx + IDX_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufAddr  <= '0;
      prdRem   <= '0;
      lastDesc <= 1'b0;
    end else if (strb.loadStart) begin
      prdRem   <= '0;
      lastDesc <= 1'b0;
    end else if (strb.fetchAck && fetchLast) begin
      bufAddr  <= {descHalf[1], descHalf[0]};
      prdRem   <= (cntField == '0) ? FULL_PRD : {1'b0, cntField};
      lastDesc <= memRdata[HW_W-1];
    end else if (strb.beatDone) begin
      bufAddr  <= bufAddr + ADDR_W'(2);
      prdRem   <= prdRem - PRD_W'(2);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) devRem <= '0;
    else if (strb.loadStart) devRem <= {devBytes[CNT_W-1:1], 1'b0};
    else if (strb.beatDone) devRem <= devRem - CNT_W'(2);
  end

  always_ff @(posedge clk) begin
    if (!rstN) heldData <= '0;
    else if (strb.holdRead) heldData <= memRdata;
  end

  // R6: a beat never runs against an empty descriptor or an empty device residue
  a_r6_beat_has_room: assert property (@(posedge clk) disable iff (!rstN)
    strb.beatDone |-> (prdRem != '0) && (devRem != '0));

  // R3: residues stay even
  a_r3_even_residue: assert property (@(posedge clk) disable iff (!rstN)
    strb.beatDone |=> !prdRem[0] && !devRem[0]);

  // R8: the table pointer never runs more than one entry past the page bound
  a_r8_ptr_bound: assert property (@(posedge clk) disable iff (!rstN)
    strb.fetchAck |=> tblOffset <= PTR_BOUND);

  // R5: descriptor length only changes on a load, a decode or a beat
  a_r5_rem_stable: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadStart && !strb.fetchAck && !strb.beatDone |=> $stable(prdRem));
endmodule

// File: rtl/prd_walk_ctrl.sv
module prd_walk_ctrl
  import prd_walk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        toHost,
  input  logic        memAck,
  input  logic        devInValid,
  input  logic        devOutReady,
  input  logic        devRemZero,
  input  logic        prdRemZero,
  input  logic        lastDesc,
  input  logic        pageHit,
  input  logic        fetchLast,
  output walkStrobe_t strb,
  output logic        memReq,
  output logic        memWrite,
  output logic        devInReady,
  output logic        devOutValid,
  output logic        busy,
  output logic        done,
  output logic        underrun
);
  walkState_t state, stateNext;
  logic dirReg;
  logic setUnderrun;

  always_comb begin
    stateNext   = state;
    strb        = '0;
    memReq      = 1'b0;
    memWrite    = 1'b0;
    devInReady  = 1'b0;
    devOutValid = 1'b0;
    setUnderrun = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strb.loadStart = 1'b1;
          stateNext = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (devRemZero) stateNext = ST_DONE;
        else if (prdRemZero) begin
          if (lastDesc || pageHit) begin
            setUnderrun = 1'b1;
            stateNext = ST_DONE;
          end else stateNext = ST_FETCH;
        end else stateNext = ST_MOVE;
      end
      ST_FETCH: begin
        strb.selTable = 1'b1;
        memReq = 1'b1;
        if (memAck) begin
          strb.fetchAck = 1'b1;
          if (fetchLast) stateNext = ST_CHECK;
        end
      end
      ST_MOVE: begin
        if (dirReg) begin
          memReq   = devInValid;
          memWrite = 1'b1;
          if (devInValid && memAck) begin
            devInReady    = 1'b1;
            strb.beatDone = 1'b1;
            stateNext     = ST_CHECK;
          end
        end else begin
          memReq = 1'b1;
          if (memAck) begin
            strb.holdRead = 1'b1;
            stateNext = ST_PUSH;
          end
        end
      end
      ST_PUSH: begin
        devOutValid = 1'b1;
        if (devOutReady) begin
          strb.beatDone = 1'b1;
          stateNext = ST_CHECK;
        end
      end
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      dirReg   <= 1'b0;
      underrun <= 1'b0;
    end else begin
      state <= stateNext;
      if (strb.loadStart) begin
        dirReg   <= toHost;
        underrun <= 1'b0;
      end else if (setUnderrun) underrun <= 1'b1;
    end
  end

  assign busy = state != ST_IDLE;
  assign done = state == ST_DONE;

  // R11: end-of-walk pulse lasts one cycle
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R1: no memory traffic outside a walk
  a_r1_req_in_walk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> busy);

  // R9: a presented halfword is held until taken
  a_r9_out_hold: assert property (@(posedge clk) disable iff (!rstN)
    devOutValid && !devOutReady |=> devOutValid);

  // R8: underrun only rises with device bytes outstanding
  a_r8_underrun_residue: assert property (@(posedge clk) disable iff (!rstN)
    $rose(underrun) |-> !devRemZero);

  // R5: table reads only when the entry is spent and device bytes remain
  a_r5_fetch_when_empty: assert property (@(posedge clk) disable iff (!rstN)
    memReq && strb.selTable |-> prdRemZero && !devRemZero);
endmodule

// File: rtl/prd_walker.sv
module prd_walker
  import prd_walk_pkg::*;
#(
  parameter int CNT_W = 20,
  parameter int PAGE_BYTES = 4096
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              toHost,
  input  logic [31:0]       tableBase,
  input  logic [CNT_W-1:0]  devBytes,
  output logic              busy,
  output logic              done,
  output logic              underrun,
  output logic              memReq,
  output logic              memWrite,
  output logic [31:0]       memAddr,
  output logic [15:0]       memWdata,
  input  logic [15:0]       memRdata,
  input  logic              memAck,
  input  logic              devInValid,
  input  logic [15:0]       devInData,
  output logic              devInReady,
  output logic              devOutValid,
  output logic [15:0]       devOutData,
  input  logic              devOutReady
);
  walkStrobe_t strb;
  logic devRemZero, prdRemZero, lastDesc, pageHit, fetchLast;

  assign memWdata = devInData;

  prd_walk_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .toHost(toHost), .memAck(memAck),
    .devInValid(devInValid), .devOutReady(devOutReady),
    .devRemZero(devRemZero), .prdRemZero(prdRemZero), .lastDesc(lastDesc),
    .pageHit(pageHit), .fetchLast(fetchLast), .strb(strb),
    .memReq(memReq), .memWrite(memWrite), .devInReady(devInReady),
    .devOutValid(devOutValid), .busy(busy), .done(done), .underrun(underrun)
  );

  prd_walk_dp #(.CNT_W(CNT_W), .PAGE_BYTES(PAGE_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .tableBase(tableBase),
    .devBytes(devBytes), .memRdata(memRdata), .memAddr(memAddr),
    .heldData(devOutData), .devRemZero(devRemZero), .prdRemZero(prdRemZero),
    .lastDesc(lastDesc), .pageHit(pageHit), .fetchLast(fetchLast)
  );
endmodule

// File: tb/prd_walker_test.sv
`timescale 1ns/1ps
module prd_walker_test;
  localparam int CNT_W = 20;
  localparam int PAGE = 64;
  localparam logic [31:0] TBL = 32'h1000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0, toHost = 1'b0;
  logic [31:0] tableBase = TBL;
  logic [CNT_W-1:0] devBytes = '0;
  logic busy, done, underrun, memReq, memWrite, memAck, devInReady, devOutValid;
  logic [31:0] memAddr;
  logic [15:0] memWdata, memRdata, devOutData;
  logic devInValid, devOutReady;
  logic [15:0] seq = '0;

  logic [15:0] tbl [64];
  logic stallMode = 1'b0;
  logic [7:0] lfsr = 8'h5B;
  logic stallNow = 1'b0, outStall = 1'b0, inStall = 1'b0;

  int checks = 0, fails = 0, cycles = 0, tblReads = 0;
  logic [31:0] wrAddr[$], rdAddr[$], expAddr[$];
  logic [15:0] wrData[$], outData[$];
  int expFetch;
  logic expUnder;

  always #2 clk = ~clk;

  prd_walker #(.CNT_W(CNT_W), .PAGE_BYTES(PAGE)) uut (
    .clk(clk), .rstN(rstN), .start(start), .toHost(toHost), .tableBase(tableBase),
    .devBytes(devBytes), .busy(busy), .done(done), .underrun(underrun),
    .memReq(memReq), .memWrite(memWrite), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memAck(memAck), .devInValid(devInValid), .devInData(seq),
    .devInReady(devInReady), .devOutValid(devOutValid), .devOutData(devOutData),
    .devOutReady(devOutReady)
  );

  function automatic logic inTable(input logic [31:0] a);
    return a >= TBL && a < TBL + 32'd128;
  endfunction

  function automatic logic [15:0] hostWord(input logic [31:0] a);
    return a[15:0] ^ a[31:16] ^ 16'hA5C3;
  endfunction

  always_comb begin
    if (inTable(memAddr)) memRdata = tbl[6'((memAddr - TBL) >> 1)];
    else memRdata = hostWord(memAddr);
  end
  assign memAck = memReq && !stallNow;
  assign devInValid = !inStall;
  assign devOutReady = !outStall;

  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    stallNow <= stallMode && lfsr[0];
    outStall <= stallMode && lfsr[2];
    inStall  <= stallMode && lfsr[5];
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rstN) begin
      if (memReq && memAck) begin
        if (memWrite) begin
          wrAddr.push_back(memAddr);
          wrData.push_back(memWdata);
        end else if (inTable(memAddr)) tblReads <= tblReads + 1;
        else rdAddr.push_back(memAddr);
      end
      if (devOutValid && devOutReady) outData.push_back(devOutData);
      if (devInValid && devInReady) seq <= seq + 16'd1;
    end
  end

  always @(posedge clk) begin
    if (cycles > 150000) begin
      checks = checks + 1;
      fails = fails + 1;
      $display("FAIL watchdog R11: actual %0d cycles, expected under 150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input logic ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic clearTbl();
    for (int i = 0; i < 64; i++) tbl[i] = 16'h0;
  endtask

  task automatic setDesc(input int i, input logic [31:0] a, input logic [31:0] c);
    tbl[i*4]   = a[15:0];
    tbl[i*4+1] = a[31:16];
    tbl[i*4+2] = c[15:0];
    tbl[i*4+3] = c[31:16];
  endtask

  // arithmetic model of the walk from the requirements
  task automatic model(input int devB);
    int ptr = 0, rem = 0, dev, idx;
    logic last = 1'b0;
    logic [31:0] a = '0;
    int c;
    expAddr.delete();
    expFetch = 0;
    expUnder = 1'b0;
    dev = devB & ~1;
    while (dev > 0) begin
      if (rem == 0) begin
        if (last || ptr >= PAGE) begin expUnder = 1'b1; break; end
        idx = ptr / 2;
        a = {tbl[idx+1], tbl[idx]};
        c = int'(tbl[idx+2]) & 32'hFFFE;
        rem = (c == 0) ? 65536 : c;
        last = tbl[idx+3][15];
        ptr += 8;
        expFetch++;
      end
      expAddr.push_back(a);
      a += 2;
      rem -= 2;
      dev -= 2;
    end
  endtask

  task automatic runWalk(input int devB, input logic dir, input logic [1:0] lowBits,
                         input logic stall, input logic poke, input string tag);
    logic [31:0] got[$];
    int bad;
    int t;
    model(devB);
    wrAddr.delete(); rdAddr.delete(); wrData.delete(); outData.delete();
    tblReads = 0;
    seq = '0;
    stallMode = stall;
    @(negedge clk);
    start = 1'b1; toHost = dir; devBytes = CNT_W'(devB);
    tableBase = TBL | {30'd0, lowBits};
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, {"R11 busy after start ", tag}, busy, 1);
    if (poke) begin
      @(negedge clk);
      start = 1'b1; tableBase = TBL + 32'h40; devBytes = CNT_W'(2); toHost = ~dir;
      @(negedge clk);
      start = 1'b0;
    end
    t = 0;
    while (done !== 1'b1 && t < 20000) begin @(negedge clk); t++; end
    check(done === 1'b1, {"R11 done seen ", tag}, done, 1);
    check(underrun === expUnder, {"R7 R8 underrun ", tag}, underrun, expUnder);
    @(negedge clk);
    check(done === 1'b0 && busy === 1'b0, {"R11 done one cycle ", tag}, {done, busy}, 0);
    check(tblReads == expFetch * 4, {"R5 R2 table reads ", tag}, tblReads, expFetch * 4);
    got = dir ? wrAddr : rdAddr;
    bad = -1;
    if (got.size() != expAddr.size()) bad = 0;
    else foreach (expAddr[k]) if (bad < 0 && got[k] !== expAddr[k]) bad = k;
    check(bad < 0, {"R6 R3 beat addresses ", tag},
          (bad < 0 || bad >= got.size()) ? longint'(got.size()) : longint'(got[bad]),
          (bad < 0 || bad >= expAddr.size()) ? longint'(expAddr.size()) : longint'(expAddr[bad]));
    bad = -1;
    if (dir) begin
      if (rdAddr.size() != 0 || wrData.size() != expAddr.size()) bad = 0;
      else foreach (wrData[k]) if (bad < 0 && wrData[k] !== 16'(k)) bad = k;
      check(bad < 0, {"R9 to-host data ", tag}, wrData.size(), expAddr.size());
    end else begin
      if (wrAddr.size() != 0 || outData.size() != expAddr.size()) bad = 0;
      else foreach (outData[k]) if (bad < 0 && outData[k] !== hostWord(expAddr[k])) bad = k;
      check(bad < 0, {"R9 from-host data ", tag}, outData.size(), expAddr.size());
    end
  endtask

  initial begin
    clearTbl();
    repeat (3) @(negedge clk);
    check(!busy && !done && !underrun && !memReq && !devInReady && !devOutValid,
          "R1 reset state", {busy, done, underrun, memReq, devInReady, devOutValid}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // three-entry table, last region crosses a 16-bit address boundary
    setDesc(0, 32'h0002_0000, 32'h0000_0006);
    setDesc(1, 32'h0003_0010, 32'h0000_0005);
    setDesc(2, 32'h0004_FFFE, 32'h8000_0008);
    for (int d = 0; d <= 24; d += 2) begin
      runWalk(d, 1'b1, 2'b00, d[1], 1'b0, $sformatf("sweep host dev=%0d", d));
      runWalk(d, 1'b0, 2'b00, ~d[1], 1'b0, $sformatf("sweep dev dev=%0d", d));
    end
    // R10: restart reloads from the base and a mid-walk start is ignored
    runWalk(18, 1'b1, 2'b00, 1'b1, 1'b1, "R10 poke while busy");
    runWalk(18, 1'b1, 2'b00, 1'b0, 1'b0, "R10 restart from base");
    // R2: misaligned base
    runWalk(12, 1'b0, 2'b11, 1'b0, 1'b0, "R2 base low bits");
    // R3: odd device total
    runWalk(13, 1'b1, 2'b00, 1'b0, 1'b0, "R3 odd device total");

    // R3: zero count means 65536 bytes, R4 set on it
    clearTbl();
    setDesc(0, 32'h0006_0000, 32'h8000_0000);
    runWalk(10, 1'b1, 2'b00, 1'b0, 1'b0, "R3 zero count");

    // R8: page bound stops a chain of non-final entries
    clearTbl();
    for (int i = 0; i < 9; i++) setDesc(i, 32'h0005_0000 + 32'(i) * 32'h100, 32'h0000_0002);
    setDesc(8, 32'h0007_0000, 32'h8000_1000);
    runWalk(100, 1'b0, 2'b00, 1'b1, 1'b0, "R8 page bound");

    // R4: final flag ends the table before the page bound
    clearTbl();
    setDesc(0, 32'h0008_0000, 32'h8000_0004);
    setDesc(1, 32'h0009_0000, 32'h0000_0004);
    runWalk(20, 1'b1, 2'b00, 1'b0, 1'b0, "R4 final flag");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule